// File: doc/BRIEF.md
# Two-Way Page Descriptor Cache

This block holds recently used page descriptors for an address translation unit. Storage is arranged as rows of two entries, a left way and a right way. A request picks its row from a section number and a row number taken from the virtual address. Each entry stores a tag, a descriptor word, a valid ("good") bit and a two-bit access-permission code. One row in each section serves each row number, so a section can be invalidated as a unit.

Requests arrive one per cycle on a single command port. The block looks up a descriptor, installs one after a table walk, invalidates a single matching entry, invalidates a whole section or the whole cache, or ORs status bits (such as modified or referenced flags) into a matching descriptor. Every request produces a registered response one cycle later. The response carries hit, way, descriptor and permission. A permission judge drives an allow flag from the registered permission and access kind. Victim choice on a fill uses one used bit per row.

Operation codes on `req_op`: 0 lookup, 1 fill, 2 invalidate matching entry, 3 invalidate section, 4 invalidate all, 5 OR-update. Codes 6 and 7 change nothing and answer as a miss.

Top module: `pdc_twoway`

## Requirements
- R1: After reset every entry is invalid. `rsp_valid` is 0 while reset is held and in the first cycle after it, and a lookup of any row after reset misses.
- R2: A request accepted at a clock edge is answered at the next edge. A lookup hits when an entry in the selected row is good and its tag equals `req_tag`, and reports its descriptor and permission. If both ways match, the left way (`rsp_side`=0) answers. On a miss, the descriptor and permission read as 0.
- R3: A fill writes the left way (`rsp_side`=0) when the left entry is not good, and clears the row's used bit.
- R4: A fill writes the right way (`rsp_side`=1) when the left entry is good and the right one is not, and sets the used bit.
- R5: When both entries are good, a fill with the used bit 1 replaces the left way and clears the used bit. With the used bit 0, it replaces the right way and sets the used bit.
- R6: Invalidate-entry clears only the first matching good entry, searching left before right. A miss leaves the cache unchanged.
- R7: Invalidate-section clears both ways of every row in the named section. Other sections are unchanged.
- R8: Invalidate-all clears every entry, so the next lookup misses.
- R9: OR-update ORs `req_mask` into the descriptor of the first matching good entry, left before right. The response shows the value held before the update. A miss changes nothing.
- R10: Permission code 0 denies every access kind.
- R11: Permission code 1 allows only access kinds 4 (fetch after a jump) and 5 (sequential instruction fetch).
- R12: Permission code 2 allows the following access kinds: 0 (interlocked read), 1 (address fetch), 2 (operand fetch), 4 and 5. It denies all other kinds (for example 3, write). Code 3 allows every kind. `rsp_allow` is 1 only for a lookup that hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_sec | input | SEC_W | Section number |
| req_row | input | ROW_W | Row within the section |
| req_tag | input | TAG_W | Tag to match or store |
| req_desc | input | DESC_W | Descriptor to store on fill |
| req_perm | input | 2 | Permission code to store on fill |
| req_mask | input | DESC_W | Bits to OR in on update |
| req_acc | input | 4 | Access kind for the permission judge |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Matching entry found |
| rsp_side | output | 1 | Way that matched or was filled (0 left, 1 right) |
| rsp_desc | output | DESC_W | Descriptor of the matching entry |
| rsp_perm | output | 2 | Permission of the matching entry |
| rsp_allow | output | 1 | Access allowed on a lookup hit |

## Verification
The bench builds the block with its default of 4 sections and 8 rows per section. At that size every section, including the first and last, can be filled and invalidated in a few dozen requests. The bench then checks that invalidating a section leaves its neighbours intact. The small row count also makes it cheap to drive one row through all three replacement cases in sequence. The bench also creates the both-ways-match case by filling the same tag twice. It sweeps all four permission codes against a range of access kinds.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [2:0] {
    OP_LOOKUP   = 3'd0,
    OP_FILL     = 3'd1,
    OP_INV_ADDR = 3'd2,
    OP_INV_SEC  = 3'd3,
    OP_INV_ALL  = 3'd4,
    OP_SET_BITS = 3'd5
  } pdc_op_e;

  typedef enum logic [3:0] {
    ACC_ILK_RD   = 4'd0,
    ACC_ADDR_FT  = 4'd1,
    ACC_OPND_FT  = 4'd2,
    ACC_WRITE    = 4'd3,
    ACC_IFT_JUMP = 4'd4,
    ACC_IFT_SEQ  = 4'd5,
    ACC_ILK_WR   = 4'd6
  } pdc_acc_e;

  localparam logic [1:0] PERM_NONE = 2'd0;
  localparam logic [1:0] PERM_EXEC = 2'd1;
  localparam logic [1:0] PERM_RDEX = 2'd2;
  localparam logic [1:0] PERM_ALL  = 2'd3;

  localparam int unsigned WAYS = 2;

endpackage

// File: rtl/pdc_perm_check.sv
module pdc_perm_check
  import pdc_pkg::*;
(
  input  logic [1:0] perm_code,
  input  logic [3:0] acc,
  output logic       allow
);

  logic is_ifetch;
  logic is_readish;

  always_comb begin
    is_ifetch  = (acc == ACC_IFT_JUMP) || (acc == ACC_IFT_SEQ);
    is_readish = (acc == ACC_ILK_RD) || (acc == ACC_ADDR_FT) || (acc == ACC_OPND_FT);
    case (perm_code)
      PERM_NONE: allow = 1'b0;
      PERM_EXEC: allow = is_ifetch;
      PERM_RDEX: allow = is_ifetch || is_readish;
      default:   allow = 1'b1;
    endcase
  end

endmodule

// File: rtl/pdc_victim.sv
module pdc_victim (
  input  logic left_good,
  input  logic right_good,
  input  logic used_in,
  output logic side,
  output logic used_out
);

  always_comb begin
    if (!left_good) begin
      side     = 1'b0;
      used_out = 1'b0;
    end else if (!right_good) begin
      side     = 1'b1;
      used_out = 1'b1;
    end else if (used_in) begin
      side     = 1'b0;
      used_out = 1'b0;
    end else begin
      side     = 1'b1;
      used_out = 1'b1;
    end
  end

endmodule

// File: rtl/pdc_way_store.sv
module pdc_way_store #(
  parameter int unsigned SECTIONS     = 4,
  parameter int unsigned ROWS_PER_SEC = 8,
  parameter int unsigned TAG_W        = 8,
  parameter int unsigned DESC_W       = 16,
  localparam int unsigned ROWS_TOTAL  = SECTIONS * ROWS_PER_SEC,
  localparam int unsigned SEC_W       = (SECTIONS > 1) ? $clog2(SECTIONS) : 1,
  localparam int unsigned IDX_W       = (ROWS_TOTAL > 1) ? $clog2(ROWS_TOTAL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_good,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DESC_W-1:0] rd_desc,
  output logic [1:0]        rd_perm,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DESC_W-1:0] wr_desc,
  input  logic [1:0]        wr_perm,
  input  logic              or_en,
  input  logic [DESC_W-1:0] or_mask,
  input  logic              inv_en,
  input  logic              sec_inv_en,
  input  logic [SEC_W-1:0]  sec_id,
  input  logic              all_inv_en
);

  logic [TAG_W-1:0]  tag_mem  [ROWS_TOTAL];
  logic [DESC_W-1:0] desc_mem [ROWS_TOTAL];
  logic [1:0]        perm_mem [ROWS_TOTAL];
  logic [ROWS_TOTAL-1:0] good_q;

  // Payload arrays: no reset, single write port.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[idx]  <= wr_tag;
      perm_mem[idx] <= wr_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      desc_mem[idx] <= wr_desc;
    end else if (or_en) begin
      desc_mem[idx] <= desc_mem[idx] | or_mask;
    end
  end

  // Valid bits live in flops so a section can be cleared in one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      good_q <= '0;
    end else begin
      for (int i = 0; i < int'(ROWS_TOTAL); i++) begin
        if (all_inv_en || (sec_inv_en && ((i / int'(ROWS_PER_SEC)) == int'(sec_id)))) begin
          good_q[i] <= 1'b0;
        end else if (i == int'(idx)) begin
          if (wr_en) begin
            good_q[i] <= 1'b1;
          end else if (inv_en) begin
            good_q[i] <= 1'b0;
          end
        end
      end
    end
  end

  assign rd_good = good_q[idx];
  assign rd_tag  = tag_mem[idx];
  assign rd_desc = desc_mem[idx];
  assign rd_perm = perm_mem[idx];

endmodule

// File: rtl/pdc_twoway.sv
module pdc_twoway
  import pdc_pkg::*;
#(
  parameter int unsigned SECTIONS     = 4,
  parameter int unsigned ROWS_PER_SEC = 8,
  parameter int unsigned TAG_W        = 8,
  parameter int unsigned DESC_W       = 16,
  parameter int unsigned SEC_W        = (SECTIONS > 1) ? $clog2(SECTIONS) : 1,
  parameter int unsigned ROW_W        = (ROWS_PER_SEC > 1) ? $clog2(ROWS_PER_SEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [SEC_W-1:0]  req_sec,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DESC_W-1:0] req_desc,
  input  logic [1:0]        req_perm,
  input  logic [DESC_W-1:0] req_mask,
  input  logic [3:0]        req_acc,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_side,
  output logic [DESC_W-1:0] rsp_desc,
  output logic [1:0]        rsp_perm,
  output logic              rsp_allow
);

  localparam int unsigned ROWS_TOTAL = SECTIONS * ROWS_PER_SEC;
  localparam int unsigned IDX_W      = (ROWS_TOTAL > 1) ? $clog2(ROWS_TOTAL) : 1;

  logic [IDX_W-1:0] idx;
  assign idx = IDX_W'({req_sec, req_row});

  logic              w_good [WAYS];
  logic [TAG_W-1:0]  w_tag  [WAYS];
  logic [DESC_W-1:0] w_desc [WAYS];
  logic [1:0]        w_perm [WAYS];

  logic is_lookup, is_fill, is_inv_addr, is_inv_sec, is_inv_all, is_set;
  logic match_l, match_r, any_match;
  logic [WAYS-1:0] hit_sel, wr_sel, inv_sel, or_sel;
  logic vic_side, vic_used;
  logic [ROWS_TOTAL-1:0] used_q;

  always_comb begin
    is_lookup   = req_valid && (req_op == OP_LOOKUP);
    is_fill     = req_valid && (req_op == OP_FILL);
    is_inv_addr = req_valid && (req_op == OP_INV_ADDR);
    is_inv_sec  = req_valid && (req_op == OP_INV_SEC);
    is_inv_all  = req_valid && (req_op == OP_INV_ALL);
    is_set      = req_valid && (req_op == OP_SET_BITS);
    match_l     = w_good[0] && (w_tag[0] == req_tag);
    match_r     = w_good[1] && (w_tag[1] == req_tag);
    any_match   = match_l || match_r;
    hit_sel     = {match_r && !match_l, match_l};
    wr_sel      = is_fill ? (vic_side ? 2'b10 : 2'b01) : 2'b00;
    inv_sel     = is_inv_addr ? hit_sel : 2'b00;
    or_sel      = is_set ? hit_sel : 2'b00;
  end

  pdc_victim u_victim (
    .left_good  (w_good[0]),
    .right_good (w_good[1]),
    .used_in    (used_q[idx]),
    .side       (vic_side),
    .used_out   (vic_used)
  );

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    pdc_way_store #(
      .SECTIONS     (SECTIONS),
      .ROWS_PER_SEC (ROWS_PER_SEC),
      .TAG_W        (TAG_W),
      .DESC_W       (DESC_W)
    ) u_store (
      .clk        (clk),
      .rst        (rst),
      .idx        (idx),
      .rd_good    (w_good[g]),
      .rd_tag     (w_tag[g]),
      .rd_desc    (w_desc[g]),
      .rd_perm    (w_perm[g]),
      .wr_en      (wr_sel[g]),
      .wr_tag     (req_tag),
      .wr_desc    (req_desc),
      .wr_perm    (req_perm),
      .or_en      (or_sel[g]),
      .or_mask    (req_mask),
      .inv_en     (inv_sel[g]),
      .sec_inv_en (is_inv_sec),
      .sec_id     (req_sec),
      .all_inv_en (is_inv_all)
    );
  end

  // Used bit: written together with the filled entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
    end else if (is_fill) begin
      used_q[idx] <= vic_used;
    end
  end

  logic       lookup_q;
  logic [3:0] acc_q;
  logic       perm_ok;
  logic       reports_match;

  assign reports_match = is_lookup || is_inv_addr || is_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_side  <= 1'b0;
      rsp_desc  <= '0;
      rsp_perm  <= '0;
      lookup_q  <= 1'b0;
      acc_q     <= '0;
    end else begin
      rsp_valid <= req_valid;
      lookup_q  <= is_lookup;
      acc_q     <= req_acc;
      rsp_hit   <= reports_match && any_match;
      if (is_fill) begin
        rsp_side <= vic_side;
      end else begin
        rsp_side <= reports_match && hit_sel[1];
      end
      if (reports_match && any_match) begin
        rsp_desc <= hit_sel[1] ? w_desc[1] : w_desc[0];
        rsp_perm <= hit_sel[1] ? w_perm[1] : w_perm[0];
      end else begin
        rsp_desc <= '0;
        rsp_perm <= '0;
      end
    end
  end

  pdc_perm_check u_perm (
    .perm_code (rsp_perm),
    .acc       (acc_q),
    .allow     (perm_ok)
  );

  assign rsp_allow = rsp_valid && rsp_hit && lookup_q && perm_ok;

endmodule

// File: rtl/pdc_twoway_chk.sv
module pdc_twoway_chk
  import pdc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic [3:0] req_acc,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic [1:0] rsp_perm,
  input logic       rsp_allow
);

  // R1: first cycle out of reset is quiet
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid);

  // R2: one response per request, one cycle later
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R3: a fill never reports a hit
  p_fill_no_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_FILL) |=> !rsp_hit);

  // R8: lookup right after invalidate-all misses
  p_all_inv_miss_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_INV_ALL) |=> ((req_valid && req_op == OP_LOOKUP) |=> !rsp_hit));

  // R10: code 0 never allows
  p_code0_denies_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_perm == PERM_NONE) |-> !rsp_allow);

  // R11: code 1 allows instruction fetch kinds only
  p_code1_ifetch_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_allow && rsp_perm == PERM_EXEC) |->
      ($past(req_acc) == ACC_IFT_JUMP || $past(req_acc) == ACC_IFT_SEQ));

  // R12: code 3 on a lookup hit always allows
  p_code3_allows_r12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit && rsp_perm == PERM_ALL && $past(req_valid) && $past(req_op) == OP_LOOKUP)
      |-> rsp_allow);

endmodule

bind pdc_twoway pdc_twoway_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_acc   (req_acc),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_perm  (rsp_perm),
  .rsp_allow (rsp_allow)
);

// File: tb/pdc_twoway_tb.sv
module pdc_twoway_tb;

  localparam int SECS = 4;
  localparam int RPS  = 8;
  localparam int NROW = SECS * RPS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_sec = '0;
  logic [2:0]  req_row = '0;
  logic [7:0]  req_tag = '0;
  logic [15:0] req_desc = '0;
  logic [1:0]  req_perm = '0;
  logic [15:0] req_mask = '0;
  logic [3:0]  req_acc = '0;
  logic        rsp_valid, rsp_hit, rsp_side, rsp_allow;
  logic [15:0] rsp_desc;
  logic [1:0]  rsp_perm;

  always #4 clk = ~clk;

  pdc_twoway #(.SECTIONS(SECS), .ROWS_PER_SEC(RPS), .TAG_W(8), .DESC_W(16)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_sec(req_sec),
    .req_row(req_row), .req_tag(req_tag), .req_desc(req_desc), .req_perm(req_perm),
    .req_mask(req_mask), .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_side(rsp_side), .rsp_desc(rsp_desc), .rsp_perm(rsp_perm), .rsp_allow(rsp_allow)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model
  logic        m_good [2][NROW];
  logic [7:0]  m_tag  [2][NROW];
  logic [15:0] m_desc [2][NROW];
  logic [1:0]  m_perm [2][NROW];
  logic        m_used [NROW];

  // scoreboard queues
  logic        q_hit[$];
  logic        q_side[$];
  logic [15:0] q_desc[$];
  logic [1:0]  q_perm[$];
  logic        q_allow[$];
  string       q_req[$];

  function automatic logic perm_ok(input logic [1:0] p, input logic [3:0] a);
    case (p)
      2'd0: return 1'b0;
      2'd1: return (a == 4'd4) || (a == 4'd5);
      2'd2: return (a == 4'd0) || (a == 4'd1) || (a == 4'd2) || (a == 4'd4) || (a == 4'd5);
      default: return 1'b1;
    endcase
  endfunction

  task automatic send(input logic [2:0] op, input int sec, input int row, input logic [7:0] tag,
                      input logic [15:0] desc, input logic [1:0] perm, input logic [15:0] mask,
                      input logic [3:0] acc, input string rq);
    int i;
    logic ml, mr, h, s, al;
    logic [15:0] d;
    logic [1:0] p;
    i  = sec * RPS + row;
    ml = m_good[0][i] && m_tag[0][i] == tag;
    mr = m_good[1][i] && m_tag[1][i] == tag;
    h = 0; s = 0; d = 0; p = 0; al = 0;
    if (op == 3'd0 || op == 3'd2 || op == 3'd5) begin
      h = ml || mr;
      s = !ml && mr;
      if (h) begin d = m_desc[s][i]; p = m_perm[s][i]; end
      if (op == 3'd0) al = h && perm_ok(p, acc);
      if (op == 3'd2 && h) m_good[s][i] = 1'b0;
      if (op == 3'd5 && h) m_desc[s][i] = m_desc[s][i] | mask;
    end else if (op == 3'd1) begin
      if (!m_good[0][i])      begin s = 0; m_used[i] = 0; end
      else if (!m_good[1][i]) begin s = 1; m_used[i] = 1; end
      else if (m_used[i])     begin s = 0; m_used[i] = 0; end
      else                    begin s = 1; m_used[i] = 1; end
      m_good[s][i] = 1; m_tag[s][i] = tag; m_desc[s][i] = desc; m_perm[s][i] = perm;
    end else if (op == 3'd3) begin
      for (int r = 0; r < RPS; r++) begin
        m_good[0][sec*RPS+r] = 0; m_good[1][sec*RPS+r] = 0;
      end
    end else if (op == 3'd4) begin
      for (int r = 0; r < NROW; r++) begin m_good[0][r] = 0; m_good[1][r] = 0; end
    end
    @(negedge clk);
    req_valid = 1; req_op = op; req_sec = 2'(sec); req_row = 3'(row); req_tag = tag;
    req_desc = desc; req_perm = perm; req_mask = mask; req_acc = acc;
    q_hit.push_back(h); q_side.push_back(s); q_desc.push_back(d);
    q_perm.push_back(p); q_allow.push_back(al); q_req.push_back(rq);
  endtask

  task automatic lookup(input int sec, input int row, input logic [7:0] tag, input logic [3:0] acc, input string rq);
    send(3'd0, sec, row, tag, 16'h0, 2'd0, 16'h0, acc, rq);
  endtask
  task automatic fill(input int sec, input int row, input logic [7:0] tag, input logic [15:0] desc, input logic [1:0] perm, input string rq);
    send(3'd1, sec, row, tag, desc, perm, 16'h0, 4'd0, rq);
  endtask
  task automatic inv_entry(input int sec, input int row, input logic [7:0] tag, input string rq);
    send(3'd2, sec, row, tag, 16'h0, 2'd0, 16'h0, 4'd0, rq);
  endtask
  task automatic inv_sec(input int sec, input string rq);
    send(3'd3, sec, 0, 8'h0, 16'h0, 2'd0, 16'h0, 4'd0, rq);
  endtask
  task automatic inv_all(input string rq);
    send(3'd4, 0, 0, 8'h0, 16'h0, 2'd0, 16'h0, 4'd0, rq);
  endtask
  task automatic set_bits(input int sec, input int row, input logic [7:0] tag, input logic [15:0] mask, input string rq);
    send(3'd5, sec, row, tag, 16'h0, 2'd0, mask, 4'd0, rq);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (q_hit.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected response hit=%0b expected no response", rsp_hit);
      end else begin
        logic eh, es, ea; logic [15:0] ed; logic [1:0] ep; string er;
        eh = q_hit.pop_front(); es = q_side.pop_front(); ed = q_desc.pop_front();
        ep = q_perm.pop_front(); ea = q_allow.pop_front(); er = q_req.pop_front();
        if (rsp_hit !== eh || rsp_side !== es || rsp_desc !== ed || rsp_perm !== ep || rsp_allow !== ea) begin
          errors++;
          $display("FAIL %s: hit/side/desc/perm/allow actual %0b/%0b/%h/%0d/%0b expected %0b/%0b/%h/%0d/%0b",
                   er, rsp_hit, rsp_side, rsp_desc, rsp_perm, rsp_allow, eh, es, ed, ep, ea);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 2; w++)
      for (int r = 0; r < NROW; r++) begin
        m_good[w][r] = 0; m_tag[w][r] = 0; m_desc[w][r] = 0; m_perm[w][r] = 0;
      end
    for (int r = 0; r < NROW; r++) m_used[r] = 0;

    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rsp_valid actual %0b expected 0", rsp_valid);
    end

    // R1: nothing hits after reset
    lookup(0, 0, 8'h00, 4'd0, "R1");
    lookup(3, 7, 8'h00, 4'd0, "R1");

    // R3/R4/R5 replacement sequence on one row
    fill(1, 3, 8'h11, 16'h1001, 2'd3, "R3");
    fill(1, 3, 8'h22, 16'h2002, 2'd3, "R4");
    fill(1, 3, 8'h33, 16'h3003, 2'd3, "R5");
    fill(1, 3, 8'h44, 16'h4004, 2'd3, "R5");
    lookup(1, 3, 8'h11, 4'd3, "R5");
    lookup(1, 3, 8'h22, 4'd3, "R5");
    lookup(1, 3, 8'h33, 4'd3, "R2");
    lookup(1, 3, 8'h44, 4'd3, "R2");
    inv_entry(1, 3, 8'h33, "R6");
    fill(1, 3, 8'h55, 16'h5005, 2'd2, "R3");
    fill(1, 3, 8'h66, 16'h6006, 2'd1, "R5");
    lookup(1, 3, 8'h44, 4'd0, "R5");
    lookup(1, 3, 8'h66, 4'd5, "R2");
    lookup(1, 3, 8'h55, 4'd1, "R2");

    // both ways hold the same tag: left answers, invalidate takes left only
    fill(2, 0, 8'hA5, 16'h0A0A, 2'd3, "R3");
    fill(2, 0, 8'hA5, 16'h0B0B, 2'd2, "R4");
    lookup(2, 0, 8'hA5, 4'd3, "R2");
    set_bits(2, 0, 8'hA5, 16'h8001, "R9");
    lookup(2, 0, 8'hA5, 4'd3, "R9");
    inv_entry(2, 0, 8'hA5, "R6");
    lookup(2, 0, 8'hA5, 4'd2, "R6");
    set_bits(2, 0, 8'hA5, 16'h0040, "R9");
    lookup(2, 0, 8'hA5, 4'd2, "R9");
    inv_entry(2, 0, 8'h5A, "R6");
    set_bits(2, 0, 8'h5A, 16'hFFFF, "R9");
    lookup(2, 0, 8'hA5, 4'd2, "R6");

    // permission sweep: rows 0..3 of section 3 carry codes 0..3
    for (int p = 0; p < 4; p++) fill(3, p, 8'hC0 + 8'(p), 16'hD000 + 16'(p), 2'(p), "R2");
    for (int a = 0; a < 8; a++) lookup(3, 0, 8'hC0, 4'(a), "R10");
    for (int a = 0; a < 8; a++) lookup(3, 1, 8'hC1, 4'(a), "R11");
    for (int a = 0; a < 8; a++) lookup(3, 2, 8'hC2, 4'(a), "R12");
    for (int a = 0; a < 8; a++) lookup(3, 3, 8'hC3, 4'(a), "R12");
    lookup(3, 3, 8'hC3, 4'd15, "R12");
    lookup(3, 1, 8'hC1, 4'd15, "R11");

    // section and full invalidation
    fill(0, 7, 8'h70, 16'h0700, 2'd3, "R3");
    fill(1, 0, 8'h10, 16'h1000, 2'd3, "R3");
    fill(2, 7, 8'h27, 16'h2700, 2'd3, "R3");
    inv_sec(1, "R7");
    lookup(1, 0, 8'h10, 4'd0, "R7");
    lookup(1, 3, 8'h55, 4'd0, "R7");
    lookup(0, 7, 8'h70, 4'd0, "R7");
    lookup(2, 7, 8'h27, 4'd0, "R7");
    lookup(3, 3, 8'hC3, 4'd0, "R7");
    inv_all("R8");
    lookup(0, 7, 8'h70, 4'd0, "R8");
    lookup(2, 7, 8'h27, 4'd0, "R8");
    lookup(3, 2, 8'hC2, 4'd0, "R8");
    fill(2, 7, 8'h28, 16'h2800, 2'd3, "R3");

    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (q_hit.size() != 0) begin
      errors++;
      $display("FAIL R2: pending responses actual %0d expected 0", q_hit.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule